// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block gathers up to fifteen device interrupt lines for a single processor. Inside it, two identical eight-input controllers are chained. The second controller (the slave) merges its own pending requests into one signal. That signal drives input 2 of the first controller (the master). A device that uses legacy line 2 is routed to slave input 1, so the processor sees it as line 9. Each controller latches rising request edges, keeps an eight-bit mask and an in-service register, and resolves priority by a fixed order in which the lowest line number wins. All slave lines share the master's line-2 priority level.

The processor reaches both controllers over a byte-wide register bus. At offset 20h the master has a command location on write and a status location on read. Its mask is at 21h. The slave uses A0h and A1h the same way. When the processor sees `int_o` high, it pulses `inta_i`. One cycle later the block returns the vector number of the winning line. The handler then ends service by writing the end-of-interrupt code to the command location. A slave line needs that write to the slave first and then to the master.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset `int_o` and `vec_valid_o` are low, both masks read FFh (all lines blocked), and both status locations read 00h.
- R2: A rising edge on an unmasked master line n (n = 0, 1, 3..7) is latched, raises `int_o`, and sets bit n of the value read at 20h.
- R3: A mask bit of 1 blocks its line and 0 enables it. Masks are written and read at 21h (master) and A1h (slave). A masked request is still latched and shows in the status read, but it does not raise `int_o` until it is unmasked.
- R4: Fixed priority: among requests that are pending and allowed, the lowest master line wins, and master line n returns vector 08h+n.
- R5: Slave line k (8..15) returns vector 70h+(k-8). Every slave line ranks below master lines 0 and 1 and above master lines 3..7. Within the slave, the lowest line wins.
- R6: A rising edge on `irq_i[2]` acts as slave line 9, with vector 71h and the same rank.
- R7: When `int_o` is high, an `inta_i` pulse makes `vec_valid_o` high for one cycle on the next cycle, with the vector on `vec_o`. It also clears the winner's latched request (status bit returns to 0) and marks the line in service.
- R8: A line in service blocks requests of equal or lower priority in its controller. A higher-priority request still raises `int_o`.
- R9: Writing 20h to a command location clears that controller's lowest-numbered in-service bit. Any other written value leaves in-service state unchanged.
- R10: An `inta_i` pulse while `int_o` is low gives no `vec_valid_o` and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 16 | Device request lines; bit 2 is the legacy line routed to slave input 1 |
| reg_addr_i | input | 8 | Register bus address |
| reg_wdata_i | input | 8 | Register bus write data |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_rdata_o | output | 8 | Register read data (combinational, zero when not reading) |
| int_o | output | 1 | Interrupt request to the processor |
| inta_i | input | 1 | Interrupt acknowledge pulse |
| vec_o | output | 8 | Vector number of the acknowledged line |
| vec_valid_o | output | 1 | `vec_o` valid for one cycle |

## Verification
Each of the sixteen inputs is first raised alone. This checks the vector mapping, the status bit, the clearing on acknowledge and the end-of-interrupt path per line, and it shows that legacy line 2 behaves as line 9. Next, every pair of distinct lines is raised together, and the bench checks that the two are served in the order of a rank it computes itself. This separates master-against-master order, master-against-cascade order (lines 0 and 1 against lines 3..7) and order within the slave. Directed sequences then cover masking on both controllers, nested service with a higher line preempting a lower one, a command value that is not end-of-interrupt, and an acknowledge while idle.

// File: rtl/cpic_pkg.sv
package cpic_pkg;
  localparam int unsigned LINES = 8;
  localparam int unsigned IW    = $clog2(LINES);
  typedef logic [LINES-1:0] line_vec_t;
  typedef logic [IW-1:0]    line_idx_t;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  // lowest set bit wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_unit.sv
module irq_unit #(
  parameter int unsigned     N           = 8,
  parameter logic [N-1:0]    LEVEL_LINES = '0,
  localparam int unsigned    IW          = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          mask_we_i,
  input  logic [N-1:0]  mask_wdata_i,
  input  logic          eoi_i,
  input  logic          ack_i,
  output logic          int_o,
  output logic [IW-1:0] win_idx_o,
  output logic [N-1:0]  irr_o,
  output logic [N-1:0]  imr_o
);
  logic [N-1:0]  req_q, irr_q, isr_q, imr_q;
  logic          pend_found, isr_found, ack_fire;
  logic [IW-1:0] pend_idx, isr_idx;

  irq_prio_enc #(.N(N)) i_pend_enc (
    .req_i(irr_q & ~imr_q), .found_o(pend_found), .idx_o(pend_idx));
  irq_prio_enc #(.N(N)) i_isr_enc (
    .req_i(isr_q), .found_o(isr_found), .idx_o(isr_idx));

  // forward only when strictly above anything in service
  assign int_o     = pend_found && (!isr_found || (pend_idx < isr_idx));
  assign ack_fire  = ack_i && int_o;
  assign win_idx_o = pend_idx;
  assign irr_o     = irr_q;
  assign imr_o     = imr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= '0;
      imr_q <= '1;
    end else begin
      req_q <= req_i;
      if (mask_we_i) imr_q <= mask_wdata_i;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_irr
    if (LEVEL_LINES[i]) begin : g_level
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) irr_q[i] <= 1'b0;
        else         irr_q[i] <= req_i[i];
      end
    end else begin : g_edge
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                  irr_q[i] <= 1'b0;
        else if (req_i[i] && !req_q[i])               irr_q[i] <= 1'b1;
        else if (ack_fire && (pend_idx == IW'(i)))    irr_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q <= '0;
    end else begin
      logic [N-1:0] isr_d;
      isr_d = isr_q;
      if (eoi_i && isr_found) isr_d[isr_idx] = 1'b0;
      if (ack_fire)           isr_d[pend_idx] = 1'b1;
      isr_q <= isr_d;
    end
  end

  AST_ACK_MARKS_SERVICE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_fire && !eoi_i) |=> ($countones(isr_q) == $past($countones(isr_q)) + 1)); // R7
  AST_EOI_RETIRES_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && isr_found && !ack_fire) |=> ($countones(isr_q) == $past($countones(isr_q)) - 1)); // R9
  AST_FULL_MASK_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_we_i && (mask_wdata_i == '1)) |=> !int_o); // R3
  AST_MASKED_NOT_FORWARDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> !imr_q[win_idx_o]); // R3
  AST_ACK_CLEARS_EDGE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_fire && !LEVEL_LINES[pend_idx] && !(req_i[pend_idx] && !req_q[pend_idx]))
      |=> !irr_q[$past(pend_idx)]); // R7
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
  import cpic_pkg::*;
#(
  parameter logic [7:0]  M_CMD_ADDR      = 8'h20,
  parameter logic [7:0]  M_MASK_ADDR     = 8'h21,
  parameter logic [7:0]  S_CMD_ADDR      = 8'hA0,
  parameter logic [7:0]  S_MASK_ADDR     = 8'hA1,
  parameter logic [7:0]  M_VEC_BASE      = 8'h08,
  parameter logic [7:0]  S_VEC_BASE      = 8'h70,
  parameter logic [7:0]  EOI_CODE        = 8'h20,
  parameter int unsigned CASC_LINE       = 2,
  parameter int unsigned LEGACY_SLAVE_IN = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2*LINES-1:0] irq_i,
  input  logic [7:0]        reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  output logic [7:0]        reg_rdata_o,
  output logic              int_o,
  input  logic              inta_i,
  output logic [7:0]        vec_o,
  output logic              vec_valid_o
);
  localparam line_idx_t CASC_IDX  = IW'(CASC_LINE);
  localparam line_vec_t CASC_MASK = line_vec_t'(1) << CASC_LINE;

  line_vec_t m_req, s_req, m_irr, s_irr, m_imr, s_imr;
  line_idx_t m_idx, s_idx;
  logic      m_int, s_int, m_casc;
  logic      m_cmd_we, s_cmd_we, m_mask_we, s_mask_we;
  logic [7:0] vec_d, vec_q;
  logic       vec_valid_q;

  always_comb begin
    m_req = irq_i[LINES-1:0];
    m_req[CASC_LINE] = s_int;
    s_req = irq_i[2*LINES-1:LINES];
    s_req[LEGACY_SLAVE_IN] = s_req[LEGACY_SLAVE_IN] | irq_i[CASC_LINE];
  end

  assign m_cmd_we  = reg_we_i && (reg_addr_i == M_CMD_ADDR);
  assign s_cmd_we  = reg_we_i && (reg_addr_i == S_CMD_ADDR);
  assign m_mask_we = reg_we_i && (reg_addr_i == M_MASK_ADDR);
  assign s_mask_we = reg_we_i && (reg_addr_i == S_MASK_ADDR);
  assign m_casc    = m_int && (m_idx == CASC_IDX);

  irq_unit #(.N(LINES), .LEVEL_LINES(CASC_MASK)) i_master (
    .clk_i, .rst_ni,
    .req_i(m_req), .mask_we_i(m_mask_we), .mask_wdata_i(reg_wdata_i[LINES-1:0]),
    .eoi_i(m_cmd_we && (reg_wdata_i == EOI_CODE)), .ack_i(inta_i),
    .int_o(m_int), .win_idx_o(m_idx), .irr_o(m_irr), .imr_o(m_imr));

  irq_unit #(.N(LINES), .LEVEL_LINES('0)) i_slave (
    .clk_i, .rst_ni,
    .req_i(s_req), .mask_we_i(s_mask_we), .mask_wdata_i(reg_wdata_i[LINES-1:0]),
    .eoi_i(s_cmd_we && (reg_wdata_i == EOI_CODE)), .ack_i(inta_i && m_casc),
    .int_o(s_int), .win_idx_o(s_idx), .irr_o(s_irr), .imr_o(s_imr));

  // cascade win with slave gone quiet: report slave's last line
  always_comb begin
    if (m_casc) vec_d = S_VEC_BASE + (s_int ? 8'(s_idx) : 8'(LINES - 1));
    else        vec_d = M_VEC_BASE + 8'(m_idx);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q       <= '0;
      vec_valid_q <= 1'b0;
    end else begin
      vec_valid_q <= inta_i && m_int;
      if (inta_i && m_int) vec_q <= vec_d;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_re_i) begin
      unique case (reg_addr_i)
        M_CMD_ADDR:  reg_rdata_o = 8'(m_irr);
        M_MASK_ADDR: reg_rdata_o = 8'(m_imr);
        S_CMD_ADDR:  reg_rdata_o = 8'(s_irr);
        S_MASK_ADDR: reg_rdata_o = 8'(s_imr);
        default:     reg_rdata_o = '0;
      endcase
    end
  end

  assign int_o       = m_int;
  assign vec_o       = vec_q;
  assign vec_valid_o = vec_valid_q;

  AST_VEC_ONLY_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> $past(inta_i)); // R7
  AST_IDLE_ACK_NO_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && !int_o) |=> !vec_valid_o); // R10
  AST_VEC_IN_WINDOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> (((vec_o >= M_VEC_BASE) && (vec_o < M_VEC_BASE + 8'(LINES))) ||
                     ((vec_o >= S_VEC_BASE) && (vec_o < S_VEC_BASE + 8'(LINES))))); // R5
  AST_VEC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |=> !vec_valid_o || $past(inta_i)); // R7
endmodule

// File: tb/test_cascade_irq_ctrl.sv
module test_cascade_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq = '0;
  logic [7:0]  addr = '0, wdata = '0;
  logic        we = 1'b0, re = 1'b0, inta = 1'b0;
  logic [7:0]  rdata, vec;
  logic        irq_out, vec_valid;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  cascade_irq_ctrl i_cascade_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_we_i(we), .reg_re_i(re),
    .reg_rdata_o(rdata), .int_o(irq_out), .inta_i(inta),
    .vec_o(vec), .vec_valid_o(vec_valid));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    tick();
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a; re = 1'b1;
    #1 d = rdata;
    re = 1'b0;
  endtask

  task automatic fire(input int n);
    irq[n] = 1'b1;
    tick();
    irq[n] = 1'b0;
    repeat (3) tick();
  endtask

  task automatic ack(output logic [7:0] v, output logic ok);
    inta = 1'b1;
    tick();
    inta = 1'b0;
    v = vec; ok = vec_valid;
  endtask

  task automatic eoi(input logic [7:0] v);
    if (v >= 8'h70) wr(8'hA0, 8'h20);
    wr(8'h20, 8'h20);
    repeat (2) tick();
  endtask

  function automatic logic [7:0] exp_vec(input int n);
    if (n == 2)     return 8'h71;
    else if (n < 8) return 8'(8 + n);
    else            return 8'(8'h70 + n - 8);
  endfunction

  function automatic int rank(input int n);
    if (n == 2)     return 32 + 1;
    else if (n < 8) return n * 16;
    else            return 32 + n - 8;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, v;
    logic ok;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 int", 16'(irq_out), 16'h0);
    chk("R1 vec_valid", 16'(vec_valid), 16'h0);
    rd(8'h21, d); chk("R1 master mask", 16'(d), 16'hFF);
    rd(8'hA1, d); chk("R1 slave mask", 16'(d), 16'hFF);
    rd(8'h20, d); chk("R1 master status", 16'(d), 16'h00);
    rd(8'hA0, d); chk("R1 slave status", 16'(d), 16'h00);

    wr(8'h21, 8'h00); wr(8'hA1, 8'h00);
    rd(8'h21, d); chk("R3 mask readback", 16'(d), 16'h00);

    // single-line sweep: R2 R4 R5 R6 R7 R8
    for (int n = 0; n < 16; n++) begin
      fire(n);
      chk($sformatf("R2 int line %0d", n), 16'(irq_out), 16'h1);
      if (n < 8 && n != 2) begin
        rd(8'h20, d); chk($sformatf("R2 status line %0d", n), 16'(d), 16'(1 << n));
      end else begin
        rd(8'hA0, d);
        chk($sformatf("R6 slave status line %0d", n), 16'(d),
            16'(1 << ((n == 2) ? 1 : n - 8)));
      end
      ack(v, ok);
      chk($sformatf("R7 valid line %0d", n), 16'(ok), 16'h1);
      chk($sformatf("R5 vector line %0d", n), 16'(v), 16'(exp_vec(n)));
      tick();
      chk($sformatf("R8 int after ack line %0d", n), 16'(irq_out), 16'h0);
      rd((n < 8 && n != 2) ? 8'h20 : 8'hA0, d);
      chk($sformatf("R7 status cleared line %0d", n), 16'(d), 16'h0);
      eoi(v);
      chk($sformatf("R9 idle after eoi line %0d", n), 16'(irq_out), 16'h0);
    end

    // pair sweep: R4 R5 R6 order
    for (int a = 0; a < 16; a++) begin
      for (int b = a + 1; b < 16; b++) begin
        int first, second;
        if (a == 2 && b == 9) continue;
        first  = (rank(a) < rank(b)) ? a : b;
        second = (first == a) ? b : a;
        fire(a); fire(b);
        ack(v, ok);
        chk($sformatf("R4 pair %0d/%0d first", a, b), 16'(v), 16'(exp_vec(first)));
        eoi(v);
        chk($sformatf("R4 pair %0d/%0d pending", a, b), 16'(irq_out), 16'h1);
        ack(v, ok);
        chk($sformatf("R5 pair %0d/%0d second", a, b), 16'(v), 16'(exp_vec(second)));
        eoi(v);
        chk($sformatf("R4 pair %0d/%0d idle", a, b), 16'(irq_out), 16'h0);
      end
    end

    // R3 master mask
    wr(8'h21, 8'h20);
    fire(5);
    chk("R3 masked master silent", 16'(irq_out), 16'h0);
    rd(8'h20, d); chk("R3 masked still latched", 16'(d), 16'h20);
    rd(8'h21, d); chk("R3 master mask readback", 16'(d), 16'h20);
    wr(8'h21, 8'h00); tick();
    chk("R3 unmask raises", 16'(irq_out), 16'h1);
    ack(v, ok); chk("R3 unmasked vector", 16'(v), 16'h0D);
    eoi(v);

    // R3 slave mask
    wr(8'hA1, 8'h10);
    fire(12);
    chk("R3 masked slave silent", 16'(irq_out), 16'h0);
    rd(8'hA1, d); chk("R3 slave mask readback", 16'(d), 16'h10);
    wr(8'hA1, 8'h00); repeat (2) tick();
    chk("R3 slave unmask raises", 16'(irq_out), 16'h1);
    ack(v, ok); chk("R3 slave vector", 16'(v), 16'h74);
    eoi(v);

    // R8 R9 nesting
    fire(4); ack(v, ok); chk("R8 nest outer vector", 16'(v), 16'h0C);
    fire(6);
    chk("R8 lower blocked", 16'(irq_out), 16'h0);
    wr(8'h20, 8'h55); tick();
    chk("R9 non-eoi ignored", 16'(irq_out), 16'h0);
    fire(1);
    chk("R8 higher preempts", 16'(irq_out), 16'h1);
    ack(v, ok); chk("R8 inner vector", 16'(v), 16'h09);
    eoi(v);
    chk("R9 eoi clears only inner", 16'(irq_out), 16'h0);
    eoi(8'h0C);
    chk("R9 second eoi frees line 6", 16'(irq_out), 16'h1);
    ack(v, ok); chk("R8 deferred vector", 16'(v), 16'h0E);
    eoi(v);

    // R10 acknowledge while idle
    chk("R10 idle before", 16'(irq_out), 16'h0);
    ack(v, ok);
    chk("R10 no vec_valid", 16'(ok), 16'h0);
    rd(8'h20, d); chk("R10 master status unchanged", 16'(d), 16'h00);
    fire(3);
    ack(v, ok); chk("R10 later ack normal", 16'(v), 16'h0B);
    eoi(v);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule